// File: doc/BRIEF.md
# Burst Address Generator

This block walks through the beats of one memory-mapped burst. A requester presents a start address, a beat count, a per-beat transfer size and a burst type, and pulses a start strobe. From the next cycle the block shows the address of the current beat. It also shows the range of byte lanes that beat occupies on the data bus, and a flag that marks the final beat. Each cycle in which the advance enable is high moves the block to the following beat. When the final beat is accepted, the block goes idle.

Three burst kinds are supported. A constant burst repeats one address, for access to a FIFO. A linear burst counts upward. It may start on an unaligned address, and only its first beat keeps that offset. A wrapping burst counts upward inside a window that is aligned to its own size. When the address passes the top of the window, it folds back to the window's base, as a cache-line fill needs. Illegal requests are refused: the block does not start them and raises an error flag instead.

Top module: `burst_addr_gen`

## Requirements
- R1: During and after reset, until the first start, active_o is 0, err_o is 0 and addr_o is 0.
- R2: One cycle after a legal start_i, active_o is 1 and addr_o equals the start address (beat 0). A start_i that arrives during a burst replaces that burst, and it wins over next_i in the same cycle.
- R3: With burst type 2'b00 (constant), every beat shows the start address.
- R4: With burst type 2'b01 (linear), beat 0 shows the start address. Beat k, for k>=1, shows the start address rounded down to a multiple of B, plus k*B, where B = 2^size_i bytes.
- R5: With burst type 2'b10 (wrapping), let W = (len_i+1)*B. Beat k shows base + ((start - base + k*B) mod W), where base is the start address rounded down to a multiple of W.
- R6: lane_lo_o equals addr_o mod DATA_BYTES. lane_hi_o is the bus lane of the last byte of the B-aligned transfer that contains addr_o.
- R7: last_o is 1 only on beat len_i of an active burst. An advance on that beat makes active_o 0 in the next cycle.
- R8: While next_i is 0, the address, lanes and beat position are held. A next_i while idle changes nothing.
- R9: A start is refused in any of these cases: burst type 2'b11; 2^size_i larger than DATA_BYTES; or a wrapping burst whose len_i is not 1, 3, 7 or 15, or whose start is not a multiple of B. In the next cycle err_o is 1 and active_o is 0. err_o stays set until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Load a new burst from the request fields |
| addr_i | input | ADDR_W | Start address |
| len_i | input | LEN_W | Beat count minus one |
| size_i | input | 3 | Log2 of bytes per beat |
| burst_i | input | 2 | Burst type: 00 constant, 01 linear, 10 wrapping |
| next_i | input | 1 | Advance to the next beat |
| active_o | output | 1 | A burst is in progress |
| addr_o | output | ADDR_W | Address of the current beat |
| lane_lo_o | output | LANE_W | Lowest valid byte lane of the beat |
| lane_hi_o | output | LANE_W | Highest valid byte lane of the beat |
| last_o | output | 1 | Current beat is the final one |
| err_o | output | 1 | Last start request was illegal |

## Verification
Some properties are checked on every cycle. The constant address holds across advances. After the first beat, linear and wrapping beats stay size-aligned, and a wrapping address never leaves its window. The beat counter never passes len_i, the burst ends after its last beat, the address holds while the block is idle, and an error never coexists with an active burst. The exact address sequence, the fold point of each window, the lane ranges of unaligned first beats and the legality decisions can only be shown by the bench. It sweeps every type, size, a set of lengths and sixteen start offsets against arithmetic expectations, with stalls and an overlapping restart.

// File: rtl/burst_pkg.sv
package burst_pkg;
  typedef enum logic [1:0] {
    BURST_FIXED = 2'b00,
    BURST_INCR  = 2'b01,
    BURST_WRAP  = 2'b10,
    BURST_RSVD  = 2'b11
  } burst_e;
endpackage

// File: rtl/burst_legal_chk.sv
module burst_legal_chk import burst_pkg::*; #(
  parameter int ADDR_W   = 32,
  parameter int LEN_W    = 8,
  parameter int SIZE_MAX = 3
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [2:0]        size_i,
  input  burst_e            burst_i,
  output logic              legal_o
);
  logic [ADDR_W-1:0] sz_mask;
  logic size_ok, wrap_len_ok, aligned;

  always_comb begin
    sz_mask     = (ADDR_W'(1) << size_i) - ADDR_W'(1);
    size_ok     = (int'(size_i) <= SIZE_MAX);
    aligned     = ((addr_i & sz_mask) == '0);
    wrap_len_ok = (len_i == LEN_W'(1)) || (len_i == LEN_W'(3)) ||
                  (len_i == LEN_W'(7)) || (len_i == LEN_W'(15));
    unique case (burst_i)
      BURST_FIXED, BURST_INCR: legal_o = size_ok;
      BURST_WRAP:              legal_o = size_ok && wrap_len_ok && aligned;
      default:                 legal_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/burst_step.sv
module burst_step import burst_pkg::*; #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 8
) (
  input  logic [ADDR_W-1:0] cur_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [2:0]        size_i,
  input  burst_e            burst_i,
  output logic [ADDR_W-1:0] next_o
);
  logic [ADDR_W-1:0] nb, aligned, lin, wmask, wbase;

  always_comb begin
    nb      = ADDR_W'(1) << size_i;
    aligned = cur_i & ~(nb - ADDR_W'(1));
    lin     = aligned + nb;
    wmask   = ((ADDR_W'(len_i) + ADDR_W'(1)) << size_i) - ADDR_W'(1);
    wbase   = base_i & ~wmask;
    unique case (burst_i)
      BURST_FIXED: next_o = cur_i;
      BURST_WRAP:  next_o = wbase | (lin & wmask);  // fold at window top
      default:     next_o = lin;
    endcase
  end
endmodule

// File: rtl/burst_lanes.sv
module burst_lanes #(
  parameter int LANE_W = 3
) (
  input  logic [LANE_W-1:0] off_i,
  input  logic [2:0]        size_i,
  output logic [LANE_W-1:0] lo_o,
  output logic [LANE_W-1:0] hi_o
);
  logic [LANE_W:0] full_mask;

  always_comb begin
    full_mask = ((LANE_W+1)'(1) << size_i) - (LANE_W+1)'(1);
    lo_o      = off_i;
    hi_o      = off_i | full_mask[LANE_W-1:0];
  end
endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr #(
  parameter int LEN_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             adv_i,
  input  logic [LEN_W-1:0] len_i,
  output logic             last_o
);
  logic [LEN_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= '0;
    else if (adv_i)  cnt_q <= cnt_q + LEN_W'(1);
  end

  assign last_o = (cnt_q == len_i);

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= len_i);  // R7
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen import burst_pkg::*; #(
  parameter int ADDR_W     = 32,
  parameter int DATA_BYTES = 8,
  parameter int LEN_W      = 8,
  localparam int LANE_W    = (DATA_BYTES > 1) ? $clog2(DATA_BYTES) : 1,
  localparam int SIZE_MAX  = $clog2(DATA_BYTES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [2:0]        size_i,
  input  logic [1:0]        burst_i,
  input  logic              next_i,
  output logic              active_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [LANE_W-1:0] lane_lo_o,
  output logic [LANE_W-1:0] lane_hi_o,
  output logic              last_o,
  output logic              err_o
);
  logic [ADDR_W-1:0] addr_q, base_q, next_addr;
  logic [LEN_W-1:0]  len_q;
  logic [2:0]        size_q;
  burst_e            burst_q, burst_in;
  logic              active_q, err_q, legal, ctr_last, adv;

  assign burst_in = burst_e'(burst_i);

  burst_legal_chk #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .SIZE_MAX(SIZE_MAX)) i_legal (
    .addr_i(addr_i), .len_i(len_i), .size_i(size_i), .burst_i(burst_in), .legal_o(legal)
  );

  burst_step #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) i_step (
    .cur_i(addr_q), .base_i(base_q), .len_i(len_q), .size_i(size_q),
    .burst_i(burst_q), .next_o(next_addr)
  );

  burst_lanes #(.LANE_W(LANE_W)) i_lanes (
    .off_i(addr_q[LANE_W-1:0]), .size_i(size_q), .lo_o(lane_lo_o), .hi_o(lane_hi_o)
  );

  assign adv = active_q && next_i && !start_i && !ctr_last;

  burst_beat_ctr #(.LEN_W(LEN_W)) i_ctr (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(start_i), .adv_i(adv),
    .len_i(len_q), .last_o(ctr_last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q   <= '0;
      base_q   <= '0;
      len_q    <= '0;
      size_q   <= '0;
      burst_q  <= BURST_FIXED;
      active_q <= 1'b0;
      err_q    <= 1'b0;
    end else if (start_i) begin
      len_q    <= len_i;
      size_q   <= size_i;
      burst_q  <= burst_in;
      active_q <= legal;
      err_q    <= !legal;
      if (legal) begin
        addr_q <= addr_i;
        base_q <= addr_i;
      end
    end else if (active_q && next_i) begin
      if (ctr_last) active_q <= 1'b0;
      else          addr_q   <= next_addr;
    end
  end

  assign active_o = active_q;
  assign addr_o   = addr_q;
  assign last_o   = active_q && ctr_last;
  assign err_o    = err_q;

  AST_FIXED_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_q && burst_q == BURST_FIXED && next_i && !start_i |=> $stable(addr_q));  // R3

  AST_ALIGN_LATER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv && burst_q != BURST_FIXED
    |=> (addr_q & ((ADDR_W'(1) << size_q) - ADDR_W'(1))) == '0);  // R4

  AST_WRAP_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_q && burst_q == BURST_WRAP
    |-> ((addr_q ^ base_q) & ~(((ADDR_W'(len_q) + ADDR_W'(1)) << size_q) - ADDR_W'(1))) == '0);  // R5

  AST_LAST_ENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o && next_i && !start_i |=> !active_o);  // R7

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_q && !start_i |=> $stable(addr_q));  // R8

  AST_ERR_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |-> !active_q);  // R9
endmodule

// File: tb/test_burst_addr_gen.sv
module test_burst_addr_gen;
  localparam int AW = 16, DB = 4, LW = 8, NW = 2;

  logic          clk = 1'b0, rst_n = 1'b0;
  logic          start = 1'b0, nxt = 1'b0;
  logic [AW-1:0] addr_in = '0;
  logic [LW-1:0] len_in = '0;
  logic [2:0]    size_in = '0;
  logic [1:0]    burst_in = '0;
  logic          active, last, err;
  logic [AW-1:0] addr;
  logic [NW-1:0] lo, hi;

  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  burst_addr_gen #(.ADDR_W(AW), .DATA_BYTES(DB), .LEN_W(LW)) i_burst_addr_gen (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .addr_i(addr_in), .len_i(len_in),
    .size_i(size_in), .burst_i(burst_in), .next_i(nxt), .active_o(active),
    .addr_o(addr), .lane_lo_o(lo), .lane_hi_o(hi), .last_o(last), .err_o(err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int exp_addr(int a, int b, int sz, int ln, int k);
    int nb = 1 << sz;
    int w  = nb * (ln + 1);
    int base;
    if (b == 0) return a;
    if (b == 1) return (k == 0) ? a : (a / nb) * nb + k * nb;
    base = a - (a % w);
    return base + ((a - base + k * nb) % w);
  endfunction

  task automatic check_beat(int ea, int sz, int b, bit el);
    int l   = ea % DB;
    int eh  = (l / (1 << sz)) * (1 << sz) + (1 << sz) - 1;
    chk(active == 1'b1, "R2", active, 1);
    chk(addr == AW'(ea), (b == 0) ? "R3" : (b == 1) ? "R4" : "R5", addr, ea);
    chk(lo == NW'(l) && hi == NW'(eh), "R6", {lo, hi}, {l[NW-1:0], eh[NW-1:0]});
    chk(last == el, "R7", last, el);
  endtask

  task automatic run_burst(int a, int b, int sz, int ln, bit stall);
    bit bad;
    int nb = 1 << sz;
    bad = (b == 3) || (nb > DB) ||
          (b == 2 && (!(ln == 1 || ln == 3 || ln == 7 || ln == 15) || (a % nb) != 0));
    start = 1'b1; addr_in = AW'(a); len_in = LW'(ln); size_in = 3'(sz); burst_in = 2'(b);
    nxt = 1'b0;
    @(negedge clk);
    start = 1'b0;
    if (bad) begin
      chk(err == 1'b1 && active == 1'b0, "R9", {err, active}, 2'b10);
      return;
    end
    chk(err == 1'b0, "R9", err, 0);
    for (int k = 0; k <= ln; k++) begin
      check_beat(exp_addr(a, b, sz, ln, k), sz, b, k == ln);
      if (stall && (k % 2 == 0)) begin
        nxt = 1'b0;
        @(negedge clk);
        check_beat(exp_addr(a, b, sz, ln, k), sz, b, k == ln);  // R8 hold
      end
      nxt = 1'b1;
      @(negedge clk);
    end
    chk(active == 1'b0, "R7", active, 0);
    @(negedge clk);  // idle cycle with next_i still high
    chk(addr == AW'(exp_addr(a, b, sz, ln, ln)) && active == 1'b0, "R8",
        addr, exp_addr(a, b, sz, ln, ln));
    nxt = 1'b0;
  endtask

  task automatic summary;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=0 expected=1");
    summary();
    $finish;
  end

  initial begin
    int lens[6] = '{0, 1, 2, 3, 7, 15};
    int idx = 0;
    repeat (2) @(negedge clk);
    chk(active == 1'b0 && err == 1'b0 && addr == '0, "R1", {active, err}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(active == 1'b0 && err == 1'b0 && addr == '0, "R1", addr, 0);

    for (int b = 0; b < 4; b++)
      for (int sz = 0; sz < 4; sz++)
        for (int li = 0; li < 6; li++)
          for (int off = 0; off < 16; off++) begin
            run_burst(16'h0140 + off, b, sz, lens[li], (idx % 3) == 0);
            idx++;
          end

    // R2: restart mid-burst, start wins over next_i
    run_burst(16'h0200, 1, 2, 0, 1'b0);
    start = 1'b1; addr_in = 16'h0300; len_in = 8'd7; size_in = 3'd1; burst_in = 2'b01;
    @(negedge clk);
    start = 1'b0; nxt = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(addr == 16'h0304, "R4", addr, 16'h0304);
    start = 1'b1; addr_in = 16'h0403; len_in = 8'd3; size_in = 3'd2; burst_in = 2'b01;
    @(negedge clk);
    start = 1'b0; nxt = 1'b0;
    chk(addr == 16'h0403 && active == 1'b1 && last == 1'b0, "R2", addr, 16'h0403);
    chk(lo == 2'd3 && hi == 2'd3, "R6", {lo, hi}, 4'hF);
    nxt = 1'b1;
    @(negedge clk);
    chk(addr == 16'h0404, "R4", addr, 16'h0404);
    nxt = 1'b0;
    // R9: error clears on the next legal start
    start = 1'b1; burst_in = 2'b11;
    @(negedge clk);
    chk(err == 1'b1 && active == 1'b0, "R9", err, 1);
    burst_in = 2'b00;
    @(negedge clk);
    start = 1'b0;
    chk(err == 1'b0 && active == 1'b1, "R9", err, 0);

    summary();
    $finish;
  end
endmodule